// File: doc/BRIEF.md
# Serial ADC Control Sequencer

This block is the digital control core of a serial-output successive-approximation converter. It runs on the converter's own system clock, which has no fixed relation to the host's serial clock. The host selects the device with an active-low select line and toggles a serial clock. The block filters the select line against noise and shifts the previous result out, MSB first. It counts serial clock falling edges to open and close the sampling window, and then runs a fixed hold-and-convert sequence. That sequence drives a successive-approximation code to the analog array and reads back a one-bit comparator decision.

The capacitor array, reference network and comparator stay outside. The comparator decision enters as `cmp_i`, and the trial code leaves as `sar_code_o`. The serial data pin is modelled as a data bit plus an output enable for the pad driver.

Top module: `adc_serial_seq`

## Requirements
- R1: A select falling edge is accepted only after the system clock has given two rising edges and then one falling edge with the select low. `data_oe_o` stays low until that point and goes high then.
- R2: While the select input is high, `data_oe_o` is low. Deasserting the select drops it at once, without waiting for a clock edge. Serial clock edges seen while the select is high start neither sampling nor a conversion.
- R3: When the select is accepted low, `data_o` shows bit 7 of the stored result. Each of the next seven serial clock falling edges moves `data_o` one bit toward bit 0.
- R4: `sampling_o` goes high after the fourth serial clock falling edge of an access and low at the eighth.
- R5: After the eighth falling edge, `holding_o` is high for exactly 4 system clock cycles. It is followed by exactly 32 cycles of `converting_o`.
- R6: Conversion resolves one bit per 4-cycle slot, starting at bit 7. The trial bit is set in the slot's first cycle. It is cleared if `cmp_i` is high in the slot's last cycle, where high means the trial code on `sar_code_o` exceeds the input. An ideal comparator therefore yields the input code.
- R7: A comparator that never reports high gives a result of 8'hFF. One that always reports high gives 8'h00.
- R8: An accepted select falling edge during the 36-cycle hold-and-convert window ends it at once. The stored result keeps the last completed value.
- R9: The falling edge count stops at eight, so further edges during a conversion are ignored. If the select stays low, a new access begins when the conversion completes, with `data_o` on bit 7 of the new result.
- R10: After reset, `data_oe_o`, `sampling_o`, `holding_o` and `converting_o` are low, `sar_code_o` is 0, and the stored result reads 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal system clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select from the host, active low |
| io_clk_i | input | 1 | Host serial clock, asynchronous to clk_i |
| cmp_i | input | 1 | Comparator: trial code exceeds the analog input |
| data_o | output | 1 | Serial result bit |
| data_oe_o | output | 1 | Enable for the tri-state data pad |
| sampling_o | output | 1 | Sample switch closed |
| holding_o | output | 1 | Hold phase active |
| converting_o | output | 1 | Bit trials in progress |
| sar_code_o | output | DATA_W | Trial code to the capacitor array |

## Verification
The bench times the select qualification to the cycle. A filter that accepted the select one edge early or late would enable the pad on the wrong sample. A pad enable that waits for a clock after the select rises would still be driving when checked within the same cycle. The bench aborts a conversion with a fresh select. A design that loaded the partial code, or kept converting, would give the wrong byte on the next read. It also keeps the select low across a whole conversion while pulsing extra serial edges. A counter that did not saturate would start a second sampling window, and one that did not restart at completion would never present the new result without a re-select.

// File: rtl/adc_seq_pkg.sv
`timescale 1ns/1ps
package adc_seq_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_HOLD = 2'd1,
        PH_CONV = 2'd2
    } conv_phase_e;
endpackage

// File: rtl/adc_sync2.sv
`timescale 1ns/1ps
module adc_sync2 #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic d_i,
    output logic q_o
);
    logic meta_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            meta_q <= RST_VAL;
            q_o    <= RST_VAL;
        end else begin
            meta_q <= d_i;
            q_o    <= meta_q;
        end
    end
endmodule

// File: rtl/adc_cs_filter.sv
`timescale 1ns/1ps
module adc_cs_filter (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic cs_ni,
    output logic cs_low_o,
    output logic cs_fall_o
);
    logic cs_sync;
    logic qual_q;
    logic seen_q;

    // two rising edges through the synchronizer
    adc_sync2 #(.RST_VAL(1'b1)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (cs_ni),
        .q_o    (cs_sync)
    );

    // then one falling edge before the level is believed
    always_ff @(negedge clk_i or negedge rst_ni) begin
        if (!rst_ni) qual_q <= 1'b1;
        else         qual_q <= cs_sync;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) seen_q <= 1'b1;
        else         seen_q <= qual_q;
    end

    assign cs_low_o  = ~qual_q;
    assign cs_fall_o = seen_q & ~qual_q;

    AST_CS_QUALIFIED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cs_fall_o |-> !cs_sync); // R1
endmodule

// File: rtl/adc_io_shifter.sv
`timescale 1ns/1ps
module adc_io_shifter #(
    parameter int DATA_W      = 8,
    parameter int SAMPLE_EDGE = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              io_clk_i,
    input  logic              cs_low_i,
    input  logic              cs_fall_i,
    input  logic              done_i,
    input  logic [DATA_W-1:0] result_i,
    output logic              data_o,
    output logic              sampling_o,
    output logic              start_o
);
    localparam int CNT_W = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] EDGE_MAX  = CNT_W'(DATA_W);
    localparam logic [CNT_W-1:0] EDGE_LAST = CNT_W'(DATA_W - 1);
    localparam logic [CNT_W-1:0] EDGE_SMP  = CNT_W'(SAMPLE_EDGE - 1);

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] shift;
        logic              sampling;
        logic              start;
        logic              io_prev;
    } shf_state_t;

    shf_state_t state_d, state_q;
    logic io_sync;
    logic io_fall;

    adc_sync2 #(.RST_VAL(1'b0)) u_io_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (io_clk_i),
        .q_o    (io_sync)
    );

    assign io_fall = state_q.io_prev & ~io_sync;

    always_comb begin
        state_d         = state_q;
        state_d.start   = 1'b0;
        state_d.io_prev = io_sync;
        if (cs_fall_i) begin
            state_d.cnt      = '0;
            state_d.shift    = result_i;
            state_d.sampling = 1'b0;
        end else if (!cs_low_i) begin
            state_d.shift    = result_i;
            state_d.sampling = 1'b0;
        end else if (done_i) begin
            state_d.cnt   = '0;
            state_d.shift = result_i;
        end else if (io_fall && (state_q.cnt < EDGE_MAX)) begin
            state_d.cnt = state_q.cnt + 1'b1;
            if (state_q.cnt < EDGE_LAST)
                state_d.shift = {state_q.shift[DATA_W-2:0], 1'b0};
            if (state_q.cnt == EDGE_SMP)
                state_d.sampling = 1'b1;
            if (state_q.cnt == EDGE_LAST) begin
                state_d.sampling = 1'b0;
                state_d.start    = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= '0;
        else         state_q <= state_d;
    end

    assign data_o     = state_q.shift[DATA_W-1];
    assign sampling_o = state_q.sampling;
    assign start_o    = state_q.start;

    AST_IO_IGNORED_CS_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cs_low_i |=> $stable(state_q.cnt)); // R2
    AST_EDGE_SATURATES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q.cnt == EDGE_MAX && cs_low_i && !cs_fall_i && !done_i) |=> state_q.cnt == EDGE_MAX); // R9
endmodule

// File: rtl/adc_sar_core.sv
`timescale 1ns/1ps
module adc_sar_core
    import adc_seq_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int HOLD_CYC    = 4,
    parameter int CYC_PER_BIT = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic              abort_i,
    input  logic              cmp_i,
    output logic [DATA_W-1:0] sar_o,
    output logic [DATA_W-1:0] result_o,
    output logic              holding_o,
    output logic              converting_o,
    output logic              done_o
);
    localparam int CONV_CYC = DATA_W * CYC_PER_BIT;
    localparam int CYC_W    = $clog2(CONV_CYC + HOLD_CYC);
    localparam logic [CYC_W-1:0] HOLD_LAST = CYC_W'(HOLD_CYC - 1);
    localparam logic [CYC_W-1:0] CONV_LAST = CYC_W'(CONV_CYC - 1);

    typedef struct packed {
        conv_phase_e       phase;
        logic [CYC_W-1:0]  cyc;
        logic [DATA_W-1:0] sar;
        logic [DATA_W-1:0] result;
        logic              done;
    } sar_state_t;

    sar_state_t state_d, state_q;
    int  slot;
    int  bit_pos;
    int  sub_pos;

    always_comb begin
        slot    = int'(state_q.cyc) / CYC_PER_BIT;
        sub_pos = int'(state_q.cyc) % CYC_PER_BIT;
        bit_pos = DATA_W - 1 - slot;
        state_d      = state_q;
        state_d.done = 1'b0;
        if (abort_i) begin
            state_d.phase = PH_IDLE;
            state_d.cyc   = '0;
        end else if (start_i) begin
            state_d.phase = PH_HOLD;
            state_d.cyc   = '0;
            state_d.sar   = '0;
        end else begin
            case (state_q.phase)
                PH_HOLD: begin
                    if (state_q.cyc == HOLD_LAST) begin
                        state_d.phase = PH_CONV;
                        state_d.cyc   = '0;
                    end else begin
                        state_d.cyc = state_q.cyc + 1'b1;
                    end
                end
                PH_CONV: begin
                    if (sub_pos == 0)
                        state_d.sar[bit_pos] = 1'b1;
                    if (sub_pos == CYC_PER_BIT - 1 && cmp_i)
                        state_d.sar[bit_pos] = 1'b0;
                    if (state_q.cyc == CONV_LAST) begin
                        state_d.phase  = PH_IDLE;
                        state_d.cyc    = '0;
                        state_d.result = state_d.sar;
                        state_d.done   = 1'b1;
                    end else begin
                        state_d.cyc = state_q.cyc + 1'b1;
                    end
                end
                default: state_d.cyc = '0;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= '{phase: PH_IDLE, default: '0};
        else         state_q <= state_d;
    end

    assign sar_o        = state_q.sar;
    assign result_o     = state_q.result;
    assign holding_o    = (state_q.phase == PH_HOLD);
    assign converting_o = (state_q.phase == PH_CONV);
    assign done_o       = state_q.done;

    AST_ABORT_KEEPS_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        abort_i |=> $stable(state_q.result)); // R8
    AST_RESULT_ONLY_AT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(state_q.phase == PH_CONV && state_q.cyc == CONV_LAST) |=> $stable(state_q.result)); // R9
    AST_HOLD_TO_CONV: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q.phase == PH_HOLD && state_q.cyc == HOLD_LAST && !abort_i && !start_i)
        |=> state_q.phase == PH_CONV); // R5
    AST_START_WHEN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_i |-> state_q.phase == PH_IDLE); // R9
endmodule

// File: rtl/adc_serial_seq.sv
`timescale 1ns/1ps
module adc_serial_seq #(
    parameter int DATA_W      = 8,
    parameter int SAMPLE_EDGE = 4,
    parameter int HOLD_CYC    = 4,
    parameter int CYC_PER_BIT = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              cs_ni,
    input  logic              io_clk_i,
    input  logic              cmp_i,
    output logic              data_o,
    output logic              data_oe_o,
    output logic              sampling_o,
    output logic              holding_o,
    output logic              converting_o,
    output logic [DATA_W-1:0] sar_code_o
);
    logic              cs_low;
    logic              cs_fall;
    logic              start;
    logic              done;
    logic [DATA_W-1:0] result;

    adc_cs_filter u_cs_filter (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .cs_ni     (cs_ni),
        .cs_low_o  (cs_low),
        .cs_fall_o (cs_fall)
    );

    adc_io_shifter #(
        .DATA_W      (DATA_W),
        .SAMPLE_EDGE (SAMPLE_EDGE)
    ) u_io_shifter (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .io_clk_i   (io_clk_i),
        .cs_low_i   (cs_low),
        .cs_fall_i  (cs_fall),
        .done_i     (done),
        .result_i   (result),
        .data_o     (data_o),
        .sampling_o (sampling_o),
        .start_o    (start)
    );

    adc_sar_core #(
        .DATA_W      (DATA_W),
        .HOLD_CYC    (HOLD_CYC),
        .CYC_PER_BIT (CYC_PER_BIT)
    ) u_sar_core (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .start_i      (start),
        .abort_i      (cs_fall),
        .cmp_i        (cmp_i),
        .sar_o        (sar_code_o),
        .result_o     (result),
        .holding_o    (holding_o),
        .converting_o (converting_o),
        .done_o       (done)
    );

    // the raw pin gates the pad so release needs no clock
    assign data_oe_o = cs_low & ~cs_ni;
endmodule

// File: tb/test_adc_serial_seq.sv
`timescale 1ns/1ps
module test_adc_serial_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       io_clk = 1'b0;
    logic       cmp;
    logic       data, data_oe, sampling, holding, converting;
    logic [7:0] sar_code;
    logic [7:0] vin = 8'h00;
    int         cmp_mode = 0;
    int         n_checks = 0;
    int         n_errors = 0;
    bit         finished = 1'b0;

    always #2.5 clk = ~clk;

    assign cmp = (cmp_mode == 0) ? (sar_code > vin) : (cmp_mode == 2);

    adc_serial_seq i_adc_serial_seq (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .cs_ni        (cs_n),
        .io_clk_i     (io_clk),
        .cmp_i        (cmp),
        .data_o       (data),
        .data_oe_o    (data_oe),
        .sampling_o   (sampling),
        .holding_o    (holding),
        .converting_o (converting),
        .sar_code_o   (sar_code)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic io_pulse();
        io_clk = 1'b1; tick(4);
        io_clk = 1'b0; tick(4);
    endtask

    task automatic begin_access();
        cs_n = 1'b0;
        tick(2);
        chk("R1 pad enabled too early", int'(data_oe), 0);
        tick(1);
        chk("R1 pad enable after qualification", int'(data_oe), 1);
    endtask

    task automatic read_bits(output logic [7:0] b);
        b[7] = data;
        for (int k = 1; k <= 7; k++) begin
            io_pulse();
            b[7-k] = data;
            if (k == 3) chk("R4 no sampling before 4th edge", int'(sampling), 0);
            if (k == 4) chk("R4 sampling after 4th edge", int'(sampling), 1);
        end
    endtask

    task automatic last_edge_measure(output int hold_n, output int conv_n);
        io_clk = 1'b1; tick(4);
        io_clk = 1'b0;
        for (int i = 0; i < 12 && !holding; i++) tick(1);
        chk("R4 sampling ends at 8th edge", int'(sampling), 0);
        hold_n = 0;
        while (holding && hold_n < 100) begin hold_n++; tick(1); end
        conv_n = 0;
        while (converting && conv_n < 100) begin conv_n++; tick(1); end
    endtask

    task automatic t_reset();
        chk("R10 reset pad enable", int'(data_oe), 0);
        chk("R10 reset sampling", int'(sampling), 0);
        chk("R10 reset holding", int'(holding), 0);
        chk("R10 reset converting", int'(converting), 0);
        chk("R10 reset trial code", int'(sar_code), 0);
    endtask

    task automatic t_ignore_cs_high();
        int seen = 0;
        cs_n = 1'b1;
        for (int k = 0; k < 8; k++) begin
            io_pulse();
            if (sampling || holding || converting || data_oe) seen++;
        end
        tick(6);
        if (sampling || holding || converting) seen++;
        chk("R2 serial clock ignored while deselected", seen, 0);
    endtask

    task automatic t_convert(input logic [7:0] v, input int mode, input logic [7:0] exp_prev,
                             input string req);
        logic [7:0] b;
        int h, c;
        vin = v; cmp_mode = mode;
        begin_access();
        read_bits(b);
        chk({req, " previous result shifted out"}, int'(b), int'(exp_prev));
        last_edge_measure(h, c);
        chk("R5 hold length", h, 4);
        chk("R5 conversion length", c, 32);
        cs_n = 1'b1;
        #0.5;
        chk("R2 pad released without a clock", int'(data_oe), 0);
        tick(4);
    endtask

    task automatic t_abort_and_held_low();
        logic [7:0] b;
        int h, c, live;
        cmp_mode = 0; vin = 8'h77;
        begin_access();
        read_bits(b);
        chk("R3 result before abort test", int'(b), 'h81);
        io_clk = 1'b1; tick(4);
        io_clk = 1'b0;
        for (int i = 0; i < 12 && !holding; i++) tick(1);
        tick(6);
        cs_n = 1'b1;
        #0.5;
        chk("R2 pad released mid conversion", int'(data_oe), 0);
        tick(4);
        vin = 8'h5A;
        cs_n = 1'b0;
        tick(4);
        chk("R8 conversion aborted", int'(holding | converting), 0);
        read_bits(b);
        chk("R8 stored result kept after abort", int'(b), 'h81);
        io_clk = 1'b1; tick(4);
        io_clk = 1'b0; tick(4);
        io_pulse();
        io_pulse();
        chk("R9 extra edges open no sampling", int'(sampling), 0);
        live = int'(holding | converting);
        chk("R9 conversion still running", live, 1);
        for (int i = 0; i < 60 && converting; i++) tick(1);
        tick(2);
        chk("R9 pad stays enabled with select low", int'(data_oe), 1);
        read_bits(b);
        chk("R9 new access without re-select", int'(b), 'h5A);
        vin = 8'hC3;
        last_edge_measure(h, c);
        chk("R5 hold length held-low access", h, 4);
        chk("R5 conversion length held-low access", c, 32);
        cs_n = 1'b1;
        tick(4);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    endtask

    initial begin
        tick(4);
        rst_n = 1'b1;
        tick(2);
        t_reset();
        t_ignore_cs_high();
        t_convert(8'hA5, 0, 8'h00, "R10");
        t_convert(8'h3C, 0, 8'hA5, "R6");
        t_convert(8'h00, 1, 8'h3C, "R6");
        t_convert(8'h00, 2, 8'hFF, "R7");
        t_convert(8'h81, 0, 8'h00, "R7");
        t_abort_and_held_low();
        t_convert(8'h10, 0, 8'hC3, "R3");
        finish_run();
    end

    initial begin
        #(200000 * 5);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule